// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer

This block is a multi-channel pulse-width timer. Each channel owns a 16-bit down counter and an active compare value. Both are loaded from a pair of software-written buffers. A channel drives one output pin. The pin goes high when the counter, just after a decrement, equals the compare value. It returns low when the channel reloads. The period and the duty cycle can therefore be changed while a channel runs, and the new values take effect only at a defined point.

Software reaches the block through a simple register port: a single-cycle write strobe and a combinational read. One shared control word holds four bits per channel: run, manual load, invert and auto-reload. Channel 0 sits at the bottom of the word. Every later channel sits at an irregular base position, and the bits in between are unused. A shared 8-bit prescaler feeds a free-running divider. Each channel picks its own tap of that divider through a 2-bit field in a divider-select register, which sets the channel's count rate.

Top module: `dntimer_pwm`

## Requirements
- R1: While reset is high, and in the cycle after it, every pin is low and the control word reads 0. All buffers, active counters and the prescaler value also reset to 0.
- R2: Register addresses are: 0 control word, 1 divider select, 2 prescaler (8 bits). For channel n, the count buffer is at 4+4n, the compare buffer at 5+4n and the read-only active counter at 6+4n. Each writable register reads back the value last written.
- R3: The control nibble of channel n starts at bit 0 for n=0 and at bit 4n+4 for n≥1. Within the nibble, run is at +0, manual load at +1, invert at +2 and auto-reload at +3. Bits outside the nibbles read 0, and a nibble affects only its own channel.
- R4: Writing a count or compare buffer leaves the active counter unchanged until a load or a reload happens.
- R5: On every clock while a channel's manual-load bit is set, the active counter and compare take the buffer values and the channel's raw output is forced low.
- R6: A running channel's counter moves only on its count ticks, and never by more than one step down. Ticks come every (P+1)·2^(S+1) clocks, where P is the prescaler and S is the channel's field at bits [2n+1:2n] of the divider-select register.
- R7: With count N and compare C (0 < C < N), a channel running with auto-reload holds its raw output high for (C+1) ticks and low for (N−C) ticks, in a period of N+1 ticks.
- R8: A compare value equal to the count, or equal to 0, never raises the raw output, so the pin stays at a constant level.
- R9: With auto-reload set, a channel whose counter is at 0 reloads both the counter and the compare from the buffers on its next tick, and it drives its raw output low.
- R10: Without auto-reload, a counter that reaches 0 stays at 0, and the pin keeps its level.
- R11: Clearing run freezes the counter. Setting run again resumes the count from the frozen value.
- R12: The invert bit XORs the pin with the channel's raw output, at once and in both phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | AW (8) | Write register address |
| wr_data | input | DW (32) | Write data |
| rd_addr | input | AW (8) | Read register address |
| rd_data | output | DW (32) | Combinational read data |
| pwm_o | output | NCH (3) | Per-channel pulse outputs |

## Verification
The bench builds the block with its defaults: three channels, 16-bit counts and a 32-bit data port. With three channels, the irregular nibble bases at bits 8 and 12 and the unused bits 4 to 7 can be exercised. Cross-talk between channels can be checked on a channel that has never been started. Small runtime choices of the prescaler and the divider tap keep each period to a few dozen clocks. Edge-to-edge measurement of the pin can then confirm the duty formula under several tick rates, in both polarities.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // bit offsets inside one channel's control nibble
    localparam int CTL_RUN = 0;
    localparam int CTL_LD  = 1;
    localparam int CTL_INV = 2;
    localparam int CTL_ARL = 3;

    // register address map
    localparam int REG_CTRL  = 0;
    localparam int REG_DIV   = 1;
    localparam int REG_PRE   = 2;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 4;
    localparam int OFS_CNT   = 0;
    localparam int OFS_CMP   = 1;
    localparam int OFS_OBS   = 2;

    typedef struct packed {
        logic arl;
        logic inv;
        logic ld;
        logic run;
    } chan_ctl_t;

    function automatic int ctl_base(input int n);
        return (n == 0) ? 0 : 4 * n + 4;
    endfunction

    function automatic int ctl_width(input int nch);
        return (nch == 1) ? 4 : 4 * nch + 4;
    endfunction

    function automatic logic [31:0] ctl_mask(input int nch);
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < nch; n++) begin
            m = m | (32'hF << ctl_base(n));
        end
        return m;
    endfunction

    // divide-by-2^(sel+1) tap mask over the free-running divider
    function automatic logic [3:0] tap_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            2'd2:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_timer_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pre_q,
    output logic          pre_tick,
    output logic [3:0]    div_cnt
);

    logic [PW-1:0] pre_cnt;

    assign pre_tick = (pre_cnt >= pre_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 4'd1;
        end else begin
            pre_cnt <= pre_cnt + PW'(1);
        end
    end

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CW     = 16,
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int PW     = 8,
    parameter int CTRL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    input  logic [NCH-1:0][CW-1:0]  act_cnt,
    output logic [CTRL_W-1:0]       ctrl_q,
    output logic [2*NCH-1:0]        div_q,
    output logic [PW-1:0]           pre_q,
    output logic [NCH-1:0][CW-1:0]  cnt_buf,
    output logic [NCH-1:0][CW-1:0]  cmp_buf
);

    localparam logic [31:0]       FULL_MASK = ctl_mask(NCH);
    localparam logic [CTRL_W-1:0] CTRL_MASK = FULL_MASK[CTRL_W-1:0];

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            pre_q   <= '0;
            cnt_buf <= '0;
            cmp_buf <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(REG_CTRL)) ctrl_q <= wr_data[CTRL_W-1:0] & CTRL_MASK;
            if (wr_addr == AW'(REG_DIV))  div_q  <= wr_data[2*NCH-1:0];
            if (wr_addr == AW'(REG_PRE))  pre_q  <= wr_data[PW-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(CH_BASE + CH_STRIDE * i + OFS_CNT))
                    cnt_buf[i] <= wr_data[CW-1:0];
                if (wr_addr == AW'(CH_BASE + CH_STRIDE * i + OFS_CMP))
                    cmp_buf[i] <= wr_data[CW-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(REG_CTRL)) rd_data = DW'(ctrl_q);
        if (rd_addr == AW'(REG_DIV))  rd_data = DW'(div_q);
        if (rd_addr == AW'(REG_PRE))  rd_data = DW'(pre_q);
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(CH_BASE + CH_STRIDE * i + OFS_CNT)) rd_data = DW'(cnt_buf[i]);
            if (rd_addr == AW'(CH_BASE + CH_STRIDE * i + OFS_CMP)) rd_data = DW'(cmp_buf[i]);
            if (rd_addr == AW'(CH_BASE + CH_STRIDE * i + OFS_OBS)) rd_data = DW'(act_cnt[i]);
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  chan_ctl_t     ctl,
    input  logic [CW-1:0] cnt_buf,
    input  logic [CW-1:0] cmp_buf,
    output logic [CW-1:0] act_cnt,
    output logic          pin
);

    logic [CW-1:0] act_cmp;
    logic [CW-1:0] next_cnt;
    logic          raw;
    logic          hit;

    assign next_cnt = act_cnt - CW'(1);
    // match is only tested on the freshly decremented value
    assign hit      = (next_cnt == act_cmp) && (act_cmp != '0);
    assign pin      = raw ^ ctl.inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cnt <= '0;
            act_cmp <= '0;
            raw     <= 1'b0;
        end else if (ctl.ld) begin
            act_cnt <= cnt_buf;
            act_cmp <= cmp_buf;
            raw     <= 1'b0;
        end else if (ctl.run && tick) begin
            if (act_cnt == '0) begin
                if (ctl.arl) begin
                    act_cnt <= cnt_buf;
                    act_cmp <= cmp_buf;
                    raw     <= 1'b0;
                end
            end else begin
                act_cnt <= next_cnt;
                if (hit) raw <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dntimer_pwm.sv
module dntimer_pwm
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int PW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] pwm_o
);

    localparam int CTRL_W = ctl_width(NCH);

    logic [CTRL_W-1:0]      ctrl_q;
    logic [2*NCH-1:0]       div_q;
    logic [PW-1:0]          pre_q;
    logic [NCH-1:0][CW-1:0] cnt_buf;
    logic [NCH-1:0][CW-1:0] cmp_buf;
    logic [NCH-1:0][CW-1:0] act_cnt;
    logic                   pre_tick;
    logic [3:0]             div_cnt;

    pwm_regs #(
        .NCH(NCH), .CW(CW), .AW(AW), .DW(DW), .PW(PW), .CTRL_W(CTRL_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .act_cnt (act_cnt),
        .ctrl_q  (ctrl_q),
        .div_q   (div_q),
        .pre_q   (pre_q),
        .cnt_buf (cnt_buf),
        .cmp_buf (cmp_buf)
    );

    pwm_prescale #(.PW(PW)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .pre_q    (pre_q),
        .pre_tick (pre_tick),
        .div_cnt  (div_cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int B = ctl_base(i);
        chan_ctl_t ctl;
        logic      tick;

        assign ctl  = chan_ctl_t'(ctrl_q[B +: 4]);
        assign tick = pre_tick && (&(div_cnt | ~tap_mask(div_q[2*i +: 2])));

        pwm_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .ctl     (ctl),
            .cnt_buf (cnt_buf[i]),
            .cmp_buf (cmp_buf[i]),
            .act_cnt (act_cnt[i]),
            .pin     (pwm_o[i])
        );
    end

endmodule

// File: rtl/dntimer_pwm_chk.sv
module dntimer_pwm_chk
    import pwm_timer_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CW     = 16,
    parameter int CTRL_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [CTRL_W-1:0]      ctrl_q,
    input logic [NCH-1:0][CW-1:0] act_cnt,
    input logic [NCH-1:0][CW-1:0] cnt_buf,
    input logic [NCH-1:0]         pwm_o
);

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (pwm_o == '0 && ctrl_q == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        localparam int B = ctl_base(i);

        p_load_copies_r5: assert property (@(posedge clk) disable iff (rst)
            ctrl_q[B + CTL_LD] |=> (act_cnt[i] == $past(cnt_buf[i])));

        p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_q[B + CTL_LD] && act_cnt[i] != '0) |=>
            (act_cnt[i] == $past(act_cnt[i]) || act_cnt[i] == $past(act_cnt[i]) - CW'(1)));

        p_oneshot_hold_r10: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_q[B + CTL_LD] && !ctrl_q[B + CTL_ARL] && act_cnt[i] == '0) |=>
            (act_cnt[i] == '0));

        p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_q[B + CTL_LD] && !ctrl_q[B + CTL_RUN]) |=> $stable(act_cnt[i]));
    end

endmodule

bind dntimer_pwm dntimer_pwm_chk #(
    .NCH(NCH), .CW(CW), .CTRL_W(CTRL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl_q  (ctrl_q),
    .act_cnt (act_cnt),
    .cnt_buf (cnt_buf),
    .pwm_o   (pwm_o)
);

// File: tb/tb_dntimer_pwm.sv
module tb_dntimer_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int WATCHDOG = 150000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [DW-1:0]  rd_data;
    logic [NCH-1:0] pwm_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [31:0] ctl_sh = '0;

    dntimer_pwm #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int base(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    task automatic wr(input int addr, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] val);
        @(negedge clk);
        rd_addr = AW'(addr);
        #1 val = rd_data;
    endtask

    task automatic set_ch(input int ch, input bit run, input bit ld, input bit inv, input bit arl);
        ctl_sh[base(ch) +: 4] = {arl, inv, ld, run};
        wr(0, ctl_sh);
    endtask

    task automatic start_ch(input int ch, input int n, input int c, input bit arl, input bit inv);
        wr(4 + 4*ch, n);
        wr(5 + 4*ch, c);
        set_ch(ch, 0, 1, inv, arl);
        set_ch(ch, 1, 0, inv, arl);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_level(input int ch, input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pwm_o[ch] !== lvl && n < 5000);
    endtask

    // measures active and idle phase lengths in clocks
    task automatic measure(input int ch, input logic act, output int hi, output int lo);
        int d;
        wait_level(ch, ~act, d);
        wait_level(ch, act, d);
        wait_level(ch, ~act, hi);
        wait_level(ch, act, lo);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, v);  check("R1 ctrl after reset", v, 0);
        check("R1 pins after reset", 32'(pwm_o), 0);
        rd(6, v);  check("R1 counter after reset", v, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(1, 32'h2D);  rd(1, v); check("R2 divider readback", v, 32'h2D);
        wr(2, 32'h7);   rd(2, v); check("R2 prescaler readback", v, 32'h7);
        wr(9, 32'h1234); rd(9, v); check("R2 cmp buffer ch1 readback", v, 32'h1234);
        wr(1, 0); wr(2, 0); wr(9, 0);
        wr(0, 32'hFFFF_FFFF); rd(0, v); check("R3 unused ctrl bits read 0", v, 32'h0000_FF0F);
        wr(0, 0);
    endtask

    task automatic t_offsets;
        logic [31:0] v;
        start_ch(2, 50, 10, 1, 0);
        idle(10);
        rd(14, v); check("R3 ch2 runs from bit 12", 32'(v < 50 && v > 0), 1);
        rd(10, v); check("R3 ch1 untouched by ch2 bits", v, 0);
        rd(6, v);  check("R3 ch0 untouched by ch2 bits", v, 0);
        set_ch(2, 0, 0, 0, 0);
    endtask

    task automatic t_buffer;
        logic [31:0] v;
        wr(4, 77);
        idle(5);
        rd(6, v); check("R4 buffer write leaves counter", v, 0);
        set_ch(0, 0, 1, 0, 0);
        set_ch(0, 0, 0, 0, 0);
        rd(6, v); check("R5 manual load copies count", v, 77);
    endtask

    task automatic t_freeze;
        logic [31:0] c1, c2, c3;
        start_ch(0, 100, 50, 1, 0);
        idle(20);
        set_ch(0, 0, 0, 0, 1);
        rd(6, c1);
        idle(20);
        rd(6, c2);
        check("R11 frozen counter stable", c2, c1);
        check("R11 counter moved before freeze", 32'(c1 < 100 && c1 > 0), 1);
        set_ch(0, 1, 0, 0, 1);
        idle(10);
        rd(6, c3);
        check("R11 resume continues down", 32'(c3 < c1), 1);
        set_ch(0, 0, 0, 0, 0);
    endtask

    task automatic t_duty(input int ch, input int n, input int c, input int sel, input int pre, input string tag);
        int hi, lo, d;
        d = (pre + 1) * (2 << sel);
        wr(2, pre);
        wr(1, sel << (2*ch));
        start_ch(ch, n, c, 1, 0);
        measure(ch, 1'b1, hi, lo);
        check({tag, " R7 high phase"}, hi, (c + 1) * d);
        check({tag, " R9 low phase after reload"}, lo, (n - c) * d);
        set_ch(ch, 0, 0, 0, 0);
        wr(1, 0); wr(2, 0);
    endtask

    task automatic t_never(input int c, input string tag);
        int bad;
        start_ch(0, 6, c, 1, 0);
        bad = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (pwm_o[0] !== 1'b0) bad++;
        end
        check({tag, " R8 pin never rises"}, bad, 0);
        set_ch(0, 0, 0, 0, 0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        start_ch(1, 5, 2, 0, 0);
        idle(40);
        rd(10, v); check("R10 one-shot stops at zero", v, 0);
        check("R10 pin holds level at stop", 32'(pwm_o[1]), 1);
        idle(30);
        rd(10, v); check("R10 still zero later", v, 0);
        set_ch(1, 0, 1, 0, 0);
        set_ch(1, 0, 0, 0, 0);
    endtask

    task automatic t_invert;
        int hi, lo;
        set_ch(0, 0, 1, 0, 0);
        set_ch(0, 0, 0, 1, 0);
        @(negedge clk);
        check("R12 invert raises idle pin", 32'(pwm_o[0]), 1);
        start_ch(0, 5, 2, 1, 1);
        measure(0, 1'b0, hi, lo);
        check("R12 inverted active phase low", hi, 6);
        check("R12 inverted idle phase high", lo, 6);
        set_ch(0, 0, 0, 0, 0);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_offsets();
        t_buffer();
        t_freeze();
        t_duty(0, 5, 2, 0, 0, "ch0 div2");
        t_duty(1, 9, 3, 2, 0, "ch1 div8 R6");
        t_duty(2, 4, 1, 0, 2, "ch2 pre3 R6");
        t_never(6, "cmp==count");
        t_never(0, "cmp==0");
        t_oneshot();
        t_invert();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule